// File: doc/BRIEF.md
# Packed Byte and Half-Word SIMD Add/Compare Unit

This block executes one packed-arithmetic operation per enabled clock on two 32-bit source words. It treats a word as four unsigned byte lanes or as two signed 16-bit halves. It supports wide addition with a sticky carry flag, so that two operations in a row add 64-bit values. It also supports byte-lane addition that either wraps or saturates, unsigned byte-lane compares, signed half-word compares and a reversal of the low 16 bits.

Every result is registered. Compares come in two flavours. One flavour returns its per-lane flags in the low bits of the result word. The other leaves the result word alone and deposits the flags in a small set of condition bits, which sit beside the carry flag. Nothing changes on an edge where the write strobe is low. An operation changes only the state that it names.

Top module: `simd_qb_unit`

## Requirements
- R1: On a clock edge with `rst_n` low, `result`, `carry_flag` and `cond_bits` all become zero.
- R2: Opcode 0 (add setting carry) loads `src_a + src_b` modulo 2^32 into `result` and loads the carry out of bit 31 into `carry_flag`.
- R3: Opcode 1 (add with carry) loads `src_a + src_b + carry_flag` modulo 2^32 into `result` and leaves `carry_flag` unchanged. Opcode 0 on the low words followed by opcode 1 on the high words gives the 64-bit sum.
- R4: Opcode 2 adds the four byte lanes independently, modulo 256 per lane. Lane i occupies bits 8i+7..8i, and no lane carries into another.
- R5: Opcode 3 adds the four byte lanes independently and clamps each lane sum to 255.
- R6: Opcodes 4, 5 and 6 compare the byte lanes as unsigned values for equal, less-than and less-or-equal. The flag for lane i goes to `result` bit i, with 1 meaning true. Result bits 31..4 are zero and the control state does not change.
- R7: Opcodes 7, 8 and 9 perform the same three unsigned byte-lane compares. They write the flag for lane i to `cond_bits[i]` and leave `result` unchanged.
- R8: Opcodes 10, 11 and 12 compare the two 16-bit halves as signed values for equal, less-than and less-or-equal. The upper half (bits 31..16) goes to `cond_bits[1]` and the lower half goes to `cond_bits[0]`. `cond_bits[3:2]` and `result` are unchanged.
- R9: Opcode 13 loads `result[15:0]` with `src_a[15:0]` in reversed bit order and loads `result[31:16]` with zero.
- R10: When `wr_en` is low, or when the opcode is 14 or 15, no output changes on the clock edge.
- R11: `carry_flag` is modified only by opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Executes the opcode on this edge when high |
| op | input | 4 | Operation select |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| result | output | 32 | Registered result word |
| carry_flag | output | 1 | Sticky carry from the add-setting-carry operation |
| cond_bits | output | 4 | Condition bits written by the compare-to-flags operations |

## Verification
The bench builds the unit with its default lane width of 8 and four lanes. At this size the values at lane edges are easy to reach: 0xFF plus one, 0x80 plus 0x80, and sums that land exactly on 255. So are the signed half-word extremes 0x8000 and 0x7FFF, which separate a signed compare from an unsigned one. A 64-bit carry chain is driven with operands whose low-word sum overflows and with operands whose full sum wraps past 2^64.

// File: rtl/simd_pkg.sv
// Package: shared opcode encoding and data geometry for the packed SIMD unit.
// Assumes the data word is an exact multiple of the lane width and splits into two halves.
package simd_pkg;
    typedef enum logic [3:0] {
        OP_ADD_SC   = 4'd0,
        OP_ADD_WC   = 4'd1,
        OP_ADD_QB   = 4'd2,
        OP_ADD_QBS  = 4'd3,
        OP_CMPR_EQ  = 4'd4,
        OP_CMPR_LT  = 4'd5,
        OP_CMPR_LE  = 4'd6,
        OP_CMPF_EQ  = 4'd7,
        OP_CMPF_LT  = 4'd8,
        OP_CMPF_LE  = 4'd9,
        OP_HCMP_EQ  = 4'd10,
        OP_HCMP_LT  = 4'd11,
        OP_HCMP_LE  = 4'd12,
        OP_BITREV   = 4'd13,
        OP_RSVD14   = 4'd14,
        OP_RSVD15   = 4'd15
    } simd_op_e;
endpackage

// File: rtl/simd_lane_adder.sv
// Module: full-width adder with carry in/out plus per-lane wrapping and saturating sums.
// Assumes DATA_W = LANE_W * NUM_LANES; lanes are unsigned and isolated from each other.
module simd_lane_adder #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int DATA_W   = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic [DATA_W-1:0] lane_wrap,
    output logic [DATA_W-1:0] lane_sat
);
    // Wide add used by the carry-chaining operations.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W:0] lsum;
        // Per-lane sum with its own carry bit, then wrap or clamp.
        always_comb begin
            lsum = {1'b0, a[g*LANE_W +: LANE_W]} + {1'b0, b[g*LANE_W +: LANE_W]};
            lane_wrap[g*LANE_W +: LANE_W] = lsum[LANE_W-1:0];
            lane_sat[g*LANE_W +: LANE_W]  = lsum[LANE_W] ? {LANE_W{1'b1}} : lsum[LANE_W-1:0];
        end

        // Checks a clamped lane never falls below either addend.
        always_comb begin
            // R5
            sat_floor_chk: assert (lane_sat[g*LANE_W +: LANE_W] >= a[g*LANE_W +: LANE_W]
                                && lane_sat[g*LANE_W +: LANE_W] >= b[g*LANE_W +: LANE_W]);
        end
    end
endmodule

// File: rtl/simd_lane_compare.sv
// Module: unsigned per-lane byte compares and signed per-half compares.
// Assumes the word divides into NUM_LANES lanes and exactly two halves; bit 1 of half flags is the upper half.
module simd_lane_compare #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int DATA_W   = LANE_W * NUM_LANES,
    localparam int HALF_W   = DATA_W / 2
) (
    input  logic [DATA_W-1:0]    a,
    input  logic [DATA_W-1:0]    b,
    output logic [NUM_LANES-1:0] lane_eq,
    output logic [NUM_LANES-1:0] lane_lt,
    output logic [NUM_LANES-1:0] lane_le,
    output logic [1:0]           half_eq,
    output logic [1:0]           half_lt,
    output logic [1:0]           half_le
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Unsigned relation of one lane pair.
        always_comb begin
            lane_eq[g] = a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W];
            lane_lt[g] = a[g*LANE_W +: LANE_W] <  b[g*LANE_W +: LANE_W];
            lane_le[g] = a[g*LANE_W +: LANE_W] <= b[g*LANE_W +: LANE_W];
        end

        // Checks less-or-equal covers both equality and less-than.
        always_comb begin
            // R6
            lane_le_cover_chk: assert (lane_le[g] == (lane_eq[g] | lane_lt[g]));
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic signed [HALF_W-1:0] ha;
        logic signed [HALF_W-1:0] hb;
        // Signed relation of one half-word pair.
        always_comb begin
            ha = $signed(a[h*HALF_W +: HALF_W]);
            hb = $signed(b[h*HALF_W +: HALF_W]);
            half_eq[h] = ha == hb;
            half_lt[h] = ha <  hb;
            half_le[h] = ha <= hb;
        end

        // Checks strict and equal outcomes of a half are exclusive.
        always_comb begin
            // R8
            half_excl_chk: assert (!(half_eq[h] && half_lt[h]));
        end
    end
endmodule

// File: rtl/simd_ctrl_reg.sv
// Module: control state holding the sticky carry and per-bit write-masked condition bits.
// Assumes the caller already qualifies the write enables with the block's write strobe.
module simd_ctrl_reg #(
    parameter int COND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carry_we,
    input  logic              carry_d,
    input  logic [COND_W-1:0] cond_mask,
    input  logic [COND_W-1:0] cond_d,
    output logic              carry_q,
    output logic [COND_W-1:0] cond_q
);
    // Carry flag register, loaded only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        carry_q <= 1'b0;
        else if (carry_we) carry_q <= carry_d;
    end

    for (genvar g = 0; g < COND_W; g++) begin : g_cond
        // One condition bit, loaded only when its mask bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n)            cond_q[g] <= 1'b0;
            else if (cond_mask[g]) cond_q[g] <= cond_d[g];
        end

        // R8
        cond_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cond_mask[g] |=> $stable(cond_q[g]));
    end
endmodule

// File: rtl/simd_qb_unit.sv
// Module: top of the packed SIMD add/compare unit; decodes the opcode and registers the result.
// Assumes one operation per enabled edge; reserved opcodes and a low strobe change nothing.
module simd_qb_unit #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int DATA_W   = LANE_W * NUM_LANES,
    localparam int HALF_W   = DATA_W / 2,
    localparam int COND_W   = NUM_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              carry_flag,
    output logic [COND_W-1:0] cond_bits
);
    import simd_pkg::*;

    simd_op_e            op_e;
    logic                add_cin;
    logic [DATA_W-1:0]   wide_sum;
    logic                wide_cout;
    logic [DATA_W-1:0]   qb_wrap;
    logic [DATA_W-1:0]   qb_sat;
    logic [NUM_LANES-1:0] b_eq, b_lt, b_le;
    logic [1:0]          h_eq, h_lt, h_le;
    logic [HALF_W-1:0]   rev_lo;
    logic                res_we;
    logic [DATA_W-1:0]   res_d;
    logic                carry_we_raw;
    logic [COND_W-1:0]   cond_mask_raw;
    logic [COND_W-1:0]   cond_d;

    assign op_e    = simd_op_e'(op);
    assign add_cin = (op_e == OP_ADD_WC) ? carry_flag : 1'b0;

    simd_lane_adder #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_adder (
        .a(src_a), .b(src_b), .cin(add_cin),
        .sum(wide_sum), .cout(wide_cout),
        .lane_wrap(qb_wrap), .lane_sat(qb_sat)
    );

    simd_lane_compare #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_cmp (
        .a(src_a), .b(src_b),
        .lane_eq(b_eq), .lane_lt(b_lt), .lane_le(b_le),
        .half_eq(h_eq), .half_lt(h_lt), .half_le(h_le)
    );

    // Reverses the bit order of the low half of the first source.
    always_comb begin
        for (int i = 0; i < HALF_W; i++) rev_lo[i] = src_a[HALF_W-1-i];
    end

    // Opcode decode: selects the next result and which control bits load.
    always_comb begin
        res_we        = 1'b0;
        res_d         = result;
        carry_we_raw  = 1'b0;
        cond_mask_raw = '0;
        cond_d        = '0;
        case (op_e)
            OP_ADD_SC:  begin res_we = 1'b1; res_d = wide_sum; carry_we_raw = 1'b1; end
            OP_ADD_WC:  begin res_we = 1'b1; res_d = wide_sum; end
            OP_ADD_QB:  begin res_we = 1'b1; res_d = qb_wrap; end
            OP_ADD_QBS: begin res_we = 1'b1; res_d = qb_sat; end
            OP_CMPR_EQ: begin res_we = 1'b1; res_d = {{(DATA_W-NUM_LANES){1'b0}}, b_eq}; end
            OP_CMPR_LT: begin res_we = 1'b1; res_d = {{(DATA_W-NUM_LANES){1'b0}}, b_lt}; end
            OP_CMPR_LE: begin res_we = 1'b1; res_d = {{(DATA_W-NUM_LANES){1'b0}}, b_le}; end
            OP_CMPF_EQ: begin cond_mask_raw = '1; cond_d = b_eq; end
            OP_CMPF_LT: begin cond_mask_raw = '1; cond_d = b_lt; end
            OP_CMPF_LE: begin cond_mask_raw = '1; cond_d = b_le; end
            OP_HCMP_EQ: begin cond_mask_raw[1:0] = 2'b11; cond_d[1:0] = h_eq; end
            OP_HCMP_LT: begin cond_mask_raw[1:0] = 2'b11; cond_d[1:0] = h_lt; end
            OP_HCMP_LE: begin cond_mask_raw[1:0] = 2'b11; cond_d[1:0] = h_le; end
            OP_BITREV:  begin res_we = 1'b1; res_d = {{HALF_W{1'b0}}, rev_lo}; end
            default:    begin res_we = 1'b0; end
        endcase
    end

    // Result register, loaded on strobed edges by result-producing opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n)               result <= '0;
        else if (wr_en && res_we) result <= res_d;
    end

    simd_ctrl_reg #(.COND_W(COND_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .carry_we(wr_en & carry_we_raw), .carry_d(wide_cout),
        .cond_mask(cond_mask_raw & {COND_W{wr_en}}), .cond_d(cond_d),
        .carry_q(carry_flag), .cond_q(cond_bits)
    );

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(result) && $stable(carry_flag) && $stable(cond_bits)));

    // R11
    carry_only_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op != 4'd0) |=> $stable(carry_flag));

    // R6
    cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op >= 4'd4 && op <= 4'd6) |=> (result[DATA_W-1:NUM_LANES] == '0));

    // R9
    rev_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == 4'd13) |=> (result[DATA_W-1:HALF_W] == '0));

    // R7
    flag_cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op >= 4'd7 && op <= 4'd12) |=> $stable(result));
endmodule

// File: tb/simd_qb_unit_bench.sv
module simd_qb_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic        carry_flag;
    logic [3:0]  cond_bits;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    simd_qb_unit u_simd_qb_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(op),
        .src_a(src_a), .src_b(src_b),
        .result(result), .carry_flag(carry_flag), .cond_bits(cond_bits)
    );

    // Vector fields: {op[4], a[32], b[32], exp_result[32], exp_carry[1], exp_cond[4]}
    localparam int NV = 21;
    localparam logic [104:0] VEC [NV] = '{
        {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'h0}, // R2
        {4'd1,  32'h00000001, 32'h00000002, 32'h00000004, 1'b1, 4'h0}, // R3
        {4'd0,  32'h12345678, 32'h11111111, 32'h23456789, 1'b0, 4'h0}, // R2
        {4'd1,  32'h00000010, 32'h00000020, 32'h00000030, 1'b0, 4'h0}, // R3
        {4'd2,  32'hFF800102, 32'h0180FF03, 32'h00000005, 1'b0, 4'h0}, // R4
        {4'd3,  32'hFF800102, 32'h0180FF03, 32'hFFFFFF05, 1'b0, 4'h0}, // R5
        {4'd4,  32'h11223344, 32'h11AA3300, 32'h0000000A, 1'b0, 4'h0}, // R6
        {4'd5,  32'h01FF7F80, 32'h02FE7F81, 32'h00000009, 1'b0, 4'h0}, // R6
        {4'd6,  32'h01FF7F80, 32'h02FE7F81, 32'h0000000B, 1'b0, 4'h0}, // R6
        {4'd7,  32'hAABBCCDD, 32'hAA00CC00, 32'h0000000B, 1'b0, 4'hA}, // R7
        {4'd8,  32'h00000000, 32'h01010101, 32'h0000000B, 1'b0, 4'hF}, // R7
        {4'd9,  32'hFF000000, 32'hFE000000, 32'h0000000B, 1'b0, 4'h7}, // R7
        {4'd10, 32'h80001234, 32'h80001235, 32'h0000000B, 1'b0, 4'h6}, // R8
        {4'd11, 32'h00018000, 32'h80007FFF, 32'h0000000B, 1'b0, 4'h5}, // R8
        {4'd12, 32'hFFFF0005, 32'hFFFF0004, 32'h0000000B, 1'b0, 4'h6}, // R8
        {4'd13, 32'hABCD0001, 32'h00000000, 32'h00008000, 1'b0, 4'h6}, // R9
        {4'd13, 32'h00001234, 32'hFFFFFFFF, 32'h00002C48, 1'b0, 4'h6}, // R9
        {4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00002C48, 1'b0, 4'h6}, // R10
        {4'd0,  32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'h6}, // R2
        {4'd2,  32'h01010101, 32'h01010101, 32'h02020202, 1'b1, 4'h6}, // R11
        {4'd4,  32'h00000000, 32'h00000000, 32'h0000000F, 1'b1, 4'h6}  // R11
    };

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        wr_en = we; op = o; src_a = a; src_b = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] s64;
        logic [31:0] exp_w;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", {result, carry_flag, cond_bits}, 37'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][104:101], VEC[i][100:69], VEC[i][68:37]);
            check($sformatf("vector %0d (R2..R11)", i), {result, carry_flag, cond_bits}, VEC[i][36:0]);
        end

        // R10: strobe low leaves every output alone
        step(1'b0, 4'd0, 32'hFFFFFFFF, 32'h00000001);
        check("R10", {result, carry_flag, cond_bits}, {32'h0000000F, 1'b1, 4'h6});
        step(1'b0, 4'd9, 32'h00000000, 32'hFFFFFFFF);
        check("R10", {result, carry_flag, cond_bits}, {32'h0000000F, 1'b1, 4'h6});

        // R3: 64-bit chains, expected from a 64-bit sum in the bench
        for (int k = 0; k < 3; k++) begin
            logic [63:0] xa, xb;
            case (k)
                0: begin xa = 64'h00000000_FFFFFFFF; xb = 64'h00000000_00000001; end
                1: begin xa = 64'hFFFFFFFF_FFFFFFFF; xb = 64'h00000000_00000001; end
                default: begin xa = 64'h12345678_9ABCDEF0; xb = 64'h0FEDCBA9_87654321; end
            endcase
            s64 = xa + xb;
            step(1'b1, 4'd0, xa[31:0], xb[31:0]);
            check("R2 low word", {5'd0, result}, {5'd0, s64[31:0]});
            step(1'b1, 4'd1, xa[63:32], xb[63:32]);
            check("R3 high word", {5'd0, result}, {5'd0, s64[63:32]});
        end

        // R4 / R5: lane sweeps around the 255 boundary
        for (int j = 0; j < 16; j++) begin
            logic [31:0] a, b, ew, es;
            for (int l = 0; l < 4; l++) begin
                logic [8:0] t;
                a[l*8 +: 8] = 8'(j * 17 + l * 3);
                b[l*8 +: 8] = 8'(255 - j * 13 + l);
                t = {1'b0, a[l*8 +: 8]} + {1'b0, b[l*8 +: 8]};
                ew[l*8 +: 8] = t[7:0];
                es[l*8 +: 8] = t[8] ? 8'hFF : t[7:0];
            end
            step(1'b1, 4'd2, a, b);
            check("R4 sweep", {5'd0, result}, {5'd0, ew});
            step(1'b1, 4'd3, a, b);
            check("R5 sweep", {5'd0, result}, {5'd0, es});
        end

        // R1: reset mid-run clears everything
        step(1'b1, 4'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        step(1'b1, 4'd7, 32'h0, 32'h0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run", {result, carry_flag, cond_bits}, 37'h0);
        rst_n = 1'b1;

        // R9: all-ones low half reverses to itself
        exp_w = 32'h0000FFFF;
        step(1'b1, 4'd13, 32'h5555FFFF, 32'h0);
        check("R9", {5'd0, result}, {5'd0, exp_w});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule